// File: doc/BRIEF.md
# Nibble XOR/XNOR Pair Bus Codec

This block is a matched encoder and decoder for a narrow on-chip bus on which switching activity matters. The encoder takes a valid-qualified data word, splits it into 4-bit nibbles, and codes each nibble against the encoded word it sent last. One of the nibble's two bit pairs is XORed with the previous encoded bits and the other pair is XNORed. A per-nibble control bit records which pairing was used, chosen by a fixed priority match on the nibble's own data bits.

The decoder keeps its own copy of the last encoded word. It removes the previous word and the pair mask selected by each control bit, and so recovers the original data. The first word after reset travels uncoded on both sides, which gives the two ends a common starting point. In normal use the encoder outputs drive the bus and the decoder inputs sample it. Both halves share one clock and one active-low reset. The reset is applied asynchronously and released through a synchronizer inside the block.

Top module: `duo_bus_codec`

## Requirements
- R1: While reset is held and in the cycles after its release, before any valid input, `enc_valid_o`, `enc_word_o`, `enc_ctrl_o`, `dec_valid_o` and `dec_data_o` are all zero.
- R2: The first valid encoder input after reset appears on `enc_word_o` unchanged, with `enc_ctrl_o` = 0.
- R3: For every later word, control bit i belongs to nibble i (bit 1 for data[7:4], bit 0 for data[3:0]). For a nibble n, n[2:1] = 01 gives 0 and n[2:1] = 10 gives 1. Any other n[2:1] gives 1 when n[0] = 0 and 0 when n[0] = 1.
- R4: When control bit i is 0, nibble i of the encoded word equals data XOR previous encoded word XOR 4'b0011: the upper pair (bits 3:2) is XORed and the lower pair (bits 1:0) is XNORed. When the control bit is 1, the mask is 4'b1100, so the upper pair is XNORed and the lower pair is XORed.
- R5: `enc_valid_o` is 1 in exactly those cycles that follow a cycle with `enc_valid_i` = 1, and the encoded word and control bits for that input appear in the same cycle.
- R6: `dec_valid_o` is 1 in exactly those cycles that follow a cycle with `dec_valid_i` = 1. The first valid decoder word after reset is passed through unchanged.
- R7: With the encoder outputs wired to the decoder inputs, every data word reappears on `dec_data_o` two cycles after it was presented, repeated words included. In particular, 0x55 sent right after a first word 0x55 encodes to 0xCC with `enc_ctrl_o` = 2'b11.
- R8: Cycles without a valid input change neither the outputs nor the stored previous word on either side. The next word is coded against the last word actually sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enc_valid_i | input | 1 | Data word on `enc_data_i` is to be sent |
| enc_data_i | input | 8 | Raw data word |
| enc_valid_o | output | 1 | Encoded word and control bits are new this cycle |
| enc_word_o | output | 8 | Encoded bus word |
| enc_ctrl_o | output | 2 | Pair-mode bit per nibble (0: upper pair XOR, 1: upper pair XNOR) |
| dec_valid_i | input | 1 | Encoded word on `dec_word_i` was received |
| dec_word_i | input | 8 | Received encoded word |
| dec_ctrl_i | input | 2 | Received pair-mode bits |
| dec_valid_o | output | 1 | Recovered word is new this cycle |
| dec_data_o | output | 8 | Recovered data word |

## Verification
The encoder registers its result, so an input presented before a clock edge is due on the encoder outputs after that edge. When the bench loops the encoder outputs back into the decoder, the recovered word is due one edge later, two edges after the input. The bench drives inputs at the falling edge and checks there. At each falling edge it compares the encoder outputs with the expectation computed one step earlier and the decoder outputs with the expectation computed two steps earlier. In idle steps it checks that the outputs hold their values. Stimulus covers all 256 data words in order, every word sent twice in a row, a pseudo-random stream with idle gaps, and resets in the middle of a stream.

// File: rtl/duo_codec_pkg.sv
package duo_codec_pkg;

  localparam int unsigned NIB_W = 4;

  // pair-mode encoding carried on the control wires
  typedef enum logic {
    PAIR_HI_XOR  = 1'b0,   // upper pair XOR, lower pair XNOR
    PAIR_HI_XNOR = 1'b1    // upper pair XNOR, lower pair XOR
  } pair_mode_e;

  // inversion mask applied on top of the plain XOR with the previous word
  function automatic logic [NIB_W-1:0] pair_mask(input logic mode);
    return mode ? 4'b1100 : 4'b0011;
  endfunction

endpackage

// File: rtl/duo_rst_sync.sv
module duo_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/duo_type_select.sv
module duo_type_select
  import duo_codec_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  output pair_mode_e       mode_o
);

  // first priority: middle pair; second priority: bit 0
  always_comb begin
    unique case (nib_i[2:1])
      2'b01:   mode_o = PAIR_HI_XOR;
      2'b10:   mode_o = PAIR_HI_XNOR;
      default: mode_o = nib_i[0] ? PAIR_HI_XOR : PAIR_HI_XNOR;
    endcase
  end

endmodule

// File: rtl/duo_encoder.sv
module duo_encoder
  import duo_codec_pkg::*;
#(
  parameter int unsigned NIBBLES = 2,
  localparam int unsigned W = NIBBLES * NIB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic [W-1:0]       data_i,
  output logic               valid_o,
  output logic [W-1:0]       word_o,
  output logic [NIBBLES-1:0] ctrl_o
);

  logic               first_q, first_d;
  logic               valid_q, valid_d;
  logic [W-1:0]       word_q, word_d;
  logic [NIBBLES-1:0] ctrl_q, ctrl_d;
  logic [NIBBLES-1:0] sel_bits;
  logic [W-1:0]       coded;

  for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
    pair_mode_e mode_w;

    duo_type_select i_sel (
      .nib_i  (data_i[g*NIB_W +: NIB_W]),
      .mode_o (mode_w)
    );

    assign sel_bits[g] = mode_w;
    assign coded[g*NIB_W +: NIB_W] = data_i[g*NIB_W +: NIB_W]
                                   ^ word_q[g*NIB_W +: NIB_W]
                                   ^ pair_mask(sel_bits[g]);

    AST_ENC_PAIR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !first_q) |=>
        ((word_o[g*NIB_W +: NIB_W] ^ $past(word_o[g*NIB_W +: NIB_W])
          ^ $past(data_i[g*NIB_W +: NIB_W])) == (ctrl_o[g] ? 4'b1100 : 4'b0011))); // R4
  end

  // next-state
  always_comb begin
    valid_d = valid_i;
    first_d = first_q;
    word_d  = word_q;
    ctrl_d  = ctrl_q;
    if (valid_i) begin
      first_d = 1'b0;
      if (first_q) begin
        word_d = data_i;
        ctrl_d = '0;
      end else begin
        word_d = coded;
        ctrl_d = sel_bits;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      first_q <= 1'b1;
      word_q  <= '0;
      ctrl_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (valid_i) begin
        first_q <= first_d;
        word_q  <= word_d;
        ctrl_q  <= ctrl_d;
      end
    end
  end

  assign valid_o = valid_q;
  assign word_o  = word_q;
  assign ctrl_o  = ctrl_q;

  AST_ENC_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o); // R5

  AST_ENC_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!valid_o && $stable(word_o) && $stable(ctrl_o))); // R8

  AST_ENC_FIRST_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && first_q) |=> (word_o == $past(data_i) && ctrl_o == '0)); // R2

endmodule

// File: rtl/duo_decoder.sv
module duo_decoder
  import duo_codec_pkg::*;
#(
  parameter int unsigned NIBBLES = 2,
  localparam int unsigned W = NIBBLES * NIB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic [W-1:0]       word_i,
  input  logic [NIBBLES-1:0] ctrl_i,
  output logic               valid_o,
  output logic [W-1:0]       data_o
);

  logic         first_q, first_d;
  logic         valid_q, valid_d;
  logic [W-1:0] prev_q, prev_d;
  logic [W-1:0] data_q, data_d;
  logic [W-1:0] recovered;

  for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
    assign recovered[g*NIB_W +: NIB_W] = word_i[g*NIB_W +: NIB_W]
                                       ^ prev_q[g*NIB_W +: NIB_W]
                                       ^ pair_mask(ctrl_i[g]);
  end

  // next-state
  always_comb begin
    valid_d = valid_i;
    first_d = first_q;
    prev_d  = prev_q;
    data_d  = data_q;
    if (valid_i) begin
      first_d = 1'b0;
      prev_d  = word_i;
      data_d  = first_q ? word_i : recovered;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      first_q <= 1'b1;
      prev_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (valid_i) begin
        first_q <= first_d;
        prev_q  <= prev_d;
        data_q  <= data_d;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  AST_DEC_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o); // R6

  AST_DEC_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!valid_o && $stable(data_o))); // R8

  AST_DEC_FIRST_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && first_q) |=> (data_o == $past(word_i))); // R6

endmodule

// File: rtl/duo_bus_codec.sv
module duo_bus_codec
  import duo_codec_pkg::*;
#(
  parameter int unsigned NIBBLES     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned W = NIBBLES * NIB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enc_valid_i,
  input  logic [W-1:0]       enc_data_i,
  output logic               enc_valid_o,
  output logic [W-1:0]       enc_word_o,
  output logic [NIBBLES-1:0] enc_ctrl_o,
  input  logic               dec_valid_i,
  input  logic [W-1:0]       dec_word_i,
  input  logic [NIBBLES-1:0] dec_ctrl_i,
  output logic               dec_valid_o,
  output logic [W-1:0]       dec_data_o
);

  logic rst_core_n;

  duo_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  duo_encoder #(.NIBBLES(NIBBLES)) i_encoder (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .valid_i (enc_valid_i),
    .data_i  (enc_data_i),
    .valid_o (enc_valid_o),
    .word_o  (enc_word_o),
    .ctrl_o  (enc_ctrl_o)
  );

  duo_decoder #(.NIBBLES(NIBBLES)) i_decoder (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .valid_i (dec_valid_i),
    .word_i  (dec_word_i),
    .ctrl_i  (dec_ctrl_i),
    .valid_o (dec_valid_o),
    .data_o  (dec_data_o)
  );

endmodule

// File: tb/test_duo_bus_codec.sv
`timescale 1ns/1ps
module test_duo_bus_codec;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enc_valid_i;
  logic [7:0] enc_data_i;
  logic       enc_valid_o;
  logic [7:0] enc_word_o;
  logic [1:0] enc_ctrl_o;
  logic       dec_valid_o;
  logic [7:0] dec_data_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  duo_bus_codec i_duo_bus_codec (
    .clk         (clk),
    .rst_n       (rst_n),
    .enc_valid_i (enc_valid_i),
    .enc_data_i  (enc_data_i),
    .enc_valid_o (enc_valid_o),
    .enc_word_o  (enc_word_o),
    .enc_ctrl_o  (enc_ctrl_o),
    .dec_valid_i (enc_valid_o),
    .dec_word_i  (enc_word_o),
    .dec_ctrl_i  (enc_ctrl_o),
    .dec_valid_o (dec_valid_o),
    .dec_data_o  (dec_data_o)
  );

  // model state
  bit         m_first;
  logic [7:0] m_prev;
  logic [1:0] m_ctrl;
  logic [7:0] m_dout;
  bit         e1_chk, e1_v;
  logic [7:0] e1_word, e1_data;
  logic [1:0] e1_ctrl;
  string      e1_wtag, e1_ctag;
  bit         e2_chk, e2_v;
  logic [7:0] e2_data;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // priority rule of R3: returns the control bit for one nibble
  function automatic logic nib_mode(input logic [3:0] n);
    if (n[2:1] == 2'b01) return 1'b0;
    if (n[2:1] == 2'b10) return 1'b1;
    return ~n[0];
  endfunction

  task automatic model_reset();
    m_first = 1; m_prev = 8'h00; m_ctrl = 2'b00; m_dout = 8'h00;
    e1_chk = 0; e2_chk = 0; e1_v = 0; e2_v = 0;
  endtask

  task automatic check_idle_state();
    check("R1", "enc_valid_o", 32'(enc_valid_o), 32'd0);
    check("R1", "enc_word_o",  32'(enc_word_o),  32'd0);
    check("R1", "enc_ctrl_o",  32'(enc_ctrl_o),  32'd0);
    check("R1", "dec_valid_o", 32'(dec_valid_o), 32'd0);
    check("R1", "dec_data_o",  32'(dec_data_o),  32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    enc_valid_i = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check_idle_state();
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_idle_state();
    model_reset();
  endtask

  // one bus cycle: check due outputs, then drive the next input
  task automatic step(input bit v, input logic [7:0] d);
    @(negedge clk);
    if (e1_chk) begin
      check("R5", "enc_valid_o", 32'(enc_valid_o), 32'(e1_v));
      check(e1_wtag, "enc_word_o", 32'(enc_word_o), 32'(e1_word));
      check(e1_ctag, "enc_ctrl_o", 32'(enc_ctrl_o), 32'(e1_ctrl));
    end
    if (e2_chk) begin
      check("R6", "dec_valid_o", 32'(dec_valid_o), 32'(e2_v));
      check("R7", "dec_data_o",  32'(dec_data_o),  32'(e2_data));
    end
    e2_chk = e1_chk;
    e2_v   = e1_v;
    if (e1_chk && e1_v) m_dout = e1_data;
    e2_data = m_dout;
    e1_wtag = v ? "R4" : "R8";
    e1_ctag = v ? "R3" : "R8";
    if (v) begin
      if (m_first) begin
        m_prev = d; m_ctrl = 2'b00; m_first = 0;
        e1_wtag = "R2"; e1_ctag = "R2";
      end else begin
        for (int i = 0; i < 2; i++) begin
          m_ctrl[i] = nib_mode(d[i*4 +: 4]);
          m_prev[i*4 +: 4] = d[i*4 +: 4] ^ m_prev[i*4 +: 4]
                           ^ (m_ctrl[i] ? 4'b1100 : 4'b0011);
        end
      end
    end
    e1_chk = 1; e1_v = v; e1_data = d;
    e1_word = m_prev; e1_ctrl = m_ctrl;
    enc_valid_i = v;
    enc_data_i  = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 0; enc_valid_i = 0; enc_data_i = 8'h00;
    model_reset();
    do_reset();

    // R2: first word uncoded, then idle hold (R8)
    step(1, 8'h5A);
    step(0, 8'hFF);
    step(0, 8'h13);
    step(1, 8'hC3);
    step(0, 8'h00);
    step(0, 8'h00);

    // R7: worked example after a fresh reset
    do_reset();
    step(1, 8'h55);
    step(1, 8'h55);
    step(0, 8'h00);
    check("R7", "example enc_word_o", 32'(enc_word_o), 32'h0000_00CC);
    check("R7", "example enc_ctrl_o", 32'(enc_ctrl_o), 32'd3);
    step(0, 8'h00);
    step(0, 8'h00);

    // R3/R4: all data words in order, back to back
    for (int k = 0; k < 256; k++) step(1, 8'(k));
    // repeated words (R7)
    for (int k = 0; k < 256; k++) begin
      step(1, 8'(k * 37 + 11));
      step(1, 8'(k * 37 + 11));
    end
    step(0, 8'h00);
    step(0, 8'h00);

    // pseudo-random stream with idle gaps (R8)
    lfsr = 16'hACE1;
    for (int k = 0; k < 2000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] != 4'd0, lfsr[15:8]);
    end

    // reset in the middle of a stream, then R2 again
    do_reset();
    step(1, 8'h96);
    for (int k = 0; k < 64; k++) step(1, 8'(k ^ 8'hA5));
    step(0, 8'h00);
    step(0, 8'h00);
    step(0, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule